// File: doc/BRIEF.md
# Switch-Fabric Frame Transmit Sequencer

This block is the control half of a 32-bit switch-fabric transmit path. A source hands it 44-bit records over a valid/ready handshake. A record is either a frame header or a 32-bit slice of payload. Only the top twelve bits of each record reach this block. They carry the frame type in bits 43:40 and the payload length in bytes in bits 39:32. The payload bits go straight to an external word-assembly datapath, which this block steers.

In every cycle the sequencer names the word the datapath must build, using a 3-bit word select. It also gives the mode for the external running column-parity accumulator, and says whether a word is emitted at all. A headered frame goes out as a header word, then a word that joins the second header extension half with the first payload half, then payload words offset by 16 bits, and finally a word that carries the last payload half and the column-parity slot. When no frame is pending, idle words fill the link. The block keeps a byte count of the frame in flight and flags the final word of each frame. It also forms the 16-bit base header and the 32-bit self-checking idle word from the fabric ready bits and the presented record.

Top module: `fab_tx_seq`

## Requirements
- R1: After the active-low asynchronous reset, the sequencer is at a frame boundary. `byte_count` is 0, `rec_ready` is 1, `last_word` is 0, and with `rec_valid` low it emits an idle word: `word_sel`=0, `vpar_mode`=0, `word_en`=1.
- R2: At a frame boundary, a valid record whose type bits 42:40 are 1 to 6 starts a frame (`word_sel`=1) and is consumed. Type bits 42:40 equal to 0 or 7 give an idle word (`word_sel`=0) and are consumed. Bit 43 plays no part in this decision.
- R3: A frame with payload length L (bits 39:32) emits the selects 1, 2, then 3 exactly n-1 times, then 4, where n = ceil(L/4) and n is never less than 1.
- R4: `vpar_mode` is 1 on a select-1 word, 2 on select-2 and select-3 words, 3 on the select-4 word, and 0 on idle words and on stall cycles.
- R5: `rec_ready` is 1 at a frame boundary and while a select-2 or select-3 word is pending. It is 0 in the cycle of the select-4 word, which consumes no record.
- R6: While a select-2 or select-3 word is pending and `rec_valid` is low, `word_en` is 0 and `vpar_mode` is 0. The pending select and `byte_count` hold until a record arrives.
- R7: `byte_count` is the number of bytes of the current frame already emitted. It becomes 4 after a select-1 word, grows by 4 after every other frame word, holds on a stall, and returns to 0 after an idle word.
- R8: `last_word` is 1 exactly in the cycle of a select-4 word.
- R9: `base_hdr` = {`fab_rdy`[1:0], type[3:0], 2'b00, length[7:0]}, taken from the presented record.
- R10: `idle_word` carries `base_hdr` in bits 31:16. Its bits 15:0 are the bitwise complement of `base_hdr`, except that bits 13:10 (the type nibble) are forced to 1111.
- R11: Asserting reset in the middle of a frame returns the sequencer at once to the boundary state of R1, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_valid | input | 1 | Source offers a record |
| rec_tag | input | 12 | Bits 43:32 of the record (type nibble, length byte) |
| fab_rdy | input | 2 | Fabric ready bits placed in the base header |
| rec_ready | output | 1 | Sequencer takes the offered record this cycle |
| word_sel | output | 3 | Word assembly select, 0 to 4 |
| word_en | output | 1 | A word is emitted this cycle |
| vpar_mode | output | 2 | Column-parity accumulator mode |
| byte_count | output | 9 | Bytes of the current frame already emitted |
| last_word | output | 1 | Final word of a frame |
| base_hdr | output | 16 | Base header formed from the presented record |
| idle_word | output | 32 | Idle word formed from the base header |

## Verification
The main sequence is tried against frames of several lengths. A length of 8 gives exactly one offset payload word. Lengths of 4 and 0 take the shortest path, where the tail follows the second word directly. A length of 5 tells rounding up apart from truncation. A length of 255 checks the largest word count and the top of the byte count. The same walk mixes in an idle type code with the upper type bit set, a frame type code with the upper bit set, and a record offered while the tail is pending, which shows whether bit 43 is kept out of the type decode and whether the tail word steals a record. A stall placed between two payload words separates holding the position from skipping ahead, and several header patterns with different ready bits expose a misplaced field in the base header or in the idle word.

// File: rtl/fab_tx_pkg.sv
package fab_tx_pkg;

  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_HEAD = 3'd1,
    SEL_EXT2 = 3'd2,
    SEL_DATA = 3'd3,
    SEL_TAIL = 3'd4
  } wsel_e;

  typedef enum logic [1:0] {
    VP_CLR   = 2'd0,
    VP_START = 2'd1,
    VP_FOLD  = 2'd2,
    VP_LAST  = 2'd3
  } vmode_e;

  typedef enum logic [1:0] {
    ST_BOUND,
    ST_EXT2,
    ST_DATA,
    ST_TAIL
  } seq_st_e;

  // A header type opens a frame when its low three bits are 1..6.
  function automatic logic is_frame_type(input logic [3:0] t);
    return (t[2:0] != 3'd0) && (t[2:0] != 3'd7);
  endfunction

  // Column-parity mode attached to each emitted word kind.
  function automatic vmode_e vmode_of(input wsel_e s);
    case (s)
      SEL_HEAD:           return VP_START;
      SEL_EXT2, SEL_DATA: return VP_FOLD;
      SEL_TAIL:           return VP_LAST;
      default:            return VP_CLR;
    endcase
  endfunction

endpackage

// File: rtl/fab_tx_ctl.sv
module fab_tx_ctl
  import fab_tx_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [LEN_W-1:0]  hdr_len,
  output logic              rec_ready,
  output logic [2:0]        word_sel,
  output logic              word_en,
  output logic [1:0]        vpar_mode,
  output logic              ev_first,
  output logic              ev_step,
  output logic              ev_idle
);

  localparam int RC_W = LEN_W - 1;

  // Records a frame needs: ceil(len/4), never less than one.
  function automatic logic [RC_W-1:0] recs_needed(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] sum;
    sum = {1'b0, len} + (LEN_W+1)'(3);
    return (len == '0) ? RC_W'(1) : sum[LEN_W:2];
  endfunction

  seq_st_e         st_q, st_d;
  logic [RC_W-1:0] rem_q, rem_d;
  wsel_e           sel_c;
  logic            en_c, rdy_c;

  always_comb begin
    sel_c = SEL_IDLE;
    en_c  = 1'b0;
    rdy_c = 1'b0;
    st_d  = st_q;
    rem_d = rem_q;
    case (st_q)
      ST_BOUND: begin
        rdy_c = 1'b1;
        en_c  = 1'b1;
        if (rec_valid && is_frame_type(hdr_type[3:0])) begin
          sel_c = SEL_HEAD;
          st_d  = ST_EXT2;
          rem_d = recs_needed(hdr_len);
        end
      end
      ST_EXT2, ST_DATA: begin
        rdy_c = 1'b1;
        sel_c = (st_q == ST_EXT2) ? SEL_EXT2 : SEL_DATA;
        en_c  = rec_valid;
        if (rec_valid) begin
          rem_d = rem_q - RC_W'(1);
          st_d  = (rem_q == RC_W'(1)) ? ST_TAIL : ST_DATA;
        end
      end
      ST_TAIL: begin
        sel_c = SEL_TAIL;
        en_c  = 1'b1;
        st_d  = ST_BOUND;
      end
      default: st_d = ST_BOUND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_BOUND;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end

  assign rec_ready = rdy_c;
  assign word_sel  = sel_c;
  assign word_en   = en_c;
  assign vpar_mode = en_c ? vmode_of(sel_c) : VP_CLR;
  assign ev_first  = en_c && (sel_c == SEL_HEAD);
  assign ev_idle   = en_c && (sel_c == SEL_IDLE);
  assign ev_step   = en_c && (sel_c == SEL_EXT2 || sel_c == SEL_DATA || sel_c == SEL_TAIL);

  // R3
  rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXT2 || st_q == ST_DATA) |-> (rem_q != '0));

  // R3
  head_then_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> (word_sel == SEL_EXT2));

  // R5
  tail_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel == SEL_TAIL) |-> !rec_ready);

  // R5
  tail_then_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel == SEL_TAIL) |=> (rec_ready && word_en));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_ready && !word_en) |=> ($stable(word_sel) && $stable(rem_q)));

endmodule

// File: rtl/fab_tx_bcnt.sv
module fab_tx_bcnt #(
  parameter int CNT_W  = 9,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_first,
  input  logic             ev_step,
  input  logic             ev_idle,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(WORD_W / 8);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic first, input logic step, input logic idle);
    if (idle)  return '0;
    if (first) return STEP;
    if (step)  return cur + STEP;
    return cur;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, ev_first, ev_step, ev_idle);
  end

  assign count = cnt_q;

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |=> (count == '0));

  // R7
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> (count == STEP));

  // R7
  step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (count == $past(count) + STEP));

  // R6
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_idle || ev_first || ev_step) |=> $stable(count));

endmodule

// File: rtl/fab_tx_hdr.sv
module fab_tx_hdr #(
  parameter int RDY_W  = 2,
  parameter int TYPE_W = 4,
  parameter int PAD_W  = 2,
  parameter int LEN_W  = 8,
  localparam int HDR_W = RDY_W + TYPE_W + PAD_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RDY_W-1:0]  fab_rdy,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [LEN_W-1:0]  hdr_len,
  output logic [HDR_W-1:0]  base_hdr,
  output logic [2*HDR_W-1:0] idle_word
);

  localparam int TYPE_LO = LEN_W + PAD_W;
  localparam int TYPE_HI = TYPE_LO + TYPE_W - 1;

  logic [HDR_W-1:0] low_half;

  assign base_hdr = {fab_rdy, hdr_type, {PAD_W{1'b0}}, hdr_len};

  for (genvar i = 0; i < HDR_W; i++) begin : g_cmp
    if (i >= TYPE_LO && i <= TYPE_HI) begin : g_force
      assign low_half[i] = 1'b1;
    end else begin : g_inv
      assign low_half[i] = ~base_hdr[i];
    end
  end

  assign idle_word = {base_hdr, low_half};

  // R10
  idle_rdy_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_word[HDR_W-1 -: RDY_W] == ~fab_rdy);

  // R10
  idle_len_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_word[LEN_W-1:0] ^ hdr_len) == {LEN_W{1'b1}});

endmodule

// File: rtl/fab_tx_seq.sv
module fab_tx_seq
  import fab_tx_pkg::*;
#(
  parameter int REC_W  = 44,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 9,
  parameter int RDY_W  = 2,
  localparam int TYPE_W = 4,
  localparam int PAD_W  = 2,
  localparam int TAG_W  = TYPE_W + LEN_W,
  localparam int HDR_W  = RDY_W + TYPE_W + PAD_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [TAG_W-1:0]  rec_tag,
  input  logic [RDY_W-1:0]  fab_rdy,
  output logic              rec_ready,
  output logic [2:0]        word_sel,
  output logic              word_en,
  output logic [1:0]        vpar_mode,
  output logic [CNT_W-1:0]  byte_count,
  output logic              last_word,
  output logic [HDR_W-1:0]  base_hdr,
  output logic [2*HDR_W-1:0] idle_word
);

  logic [TYPE_W-1:0] hdr_type;
  logic [LEN_W-1:0]  hdr_len;
  logic              ev_first, ev_step, ev_idle;

  assign hdr_type = rec_tag[TAG_W-1 -: TYPE_W];
  assign hdr_len  = rec_tag[LEN_W-1:0];

  fab_tx_ctl #(.LEN_W(LEN_W), .TYPE_W(TYPE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid),
    .hdr_type(hdr_type), .hdr_len(hdr_len),
    .rec_ready(rec_ready), .word_sel(word_sel), .word_en(word_en),
    .vpar_mode(vpar_mode),
    .ev_first(ev_first), .ev_step(ev_step), .ev_idle(ev_idle)
  );

  fab_tx_bcnt #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_bcnt (
    .clk(clk), .rst_n(rst_n),
    .ev_first(ev_first), .ev_step(ev_step), .ev_idle(ev_idle),
    .count(byte_count)
  );

  fab_tx_hdr #(.RDY_W(RDY_W), .TYPE_W(TYPE_W), .PAD_W(PAD_W), .LEN_W(LEN_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .fab_rdy(fab_rdy),
    .hdr_type(hdr_type), .hdr_len(hdr_len),
    .base_hdr(base_hdr), .idle_word(idle_word)
  );

  assign last_word = word_en && (word_sel == SEL_TAIL);

  // R8
  last_then_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> rec_ready);

  // R8
  last_vpar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |-> (vpar_mode == VP_LAST && !rec_ready));

  // R4
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_sel <= 3'd4);

endmodule

// File: tb/fab_tx_seq_test.sv
module fab_tx_seq_test;

  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [11:0] rec_tag = '0;
  logic [1:0]  fab_rdy = 2'b00;
  logic        rec_ready, word_en, last_word;
  logic [2:0]  word_sel;
  logic [1:0]  vpar_mode;
  logic [8:0]  byte_count;
  logic [15:0] base_hdr;
  logic [31:0] idle_word;

  int checks = 0;
  int errors = 0;

  always #(TCK/2) clk = ~clk;

  fab_tx_seq uut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_tag(rec_tag),
    .fab_rdy(fab_rdy), .rec_ready(rec_ready), .word_sel(word_sel),
    .word_en(word_en), .vpar_mode(vpar_mode), .byte_count(byte_count),
    .last_word(last_word), .base_hdr(base_hdr), .idle_word(idle_word)
  );

  // Row: {valid, type, len, sel, vpar, en, ready, last, count}
  localparam int NROW = 22;
  localparam logic [29:0] TBL [0:NROW-1] = '{
    {1'b0,4'h0,8'd0, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd0},   // R1 idle
    {1'b1,4'h1,8'd8, 3'd1,2'd1,1'b1,1'b1,1'b0,9'd0},   // R2 unicast, n=2
    {1'b1,4'h0,8'd0, 3'd2,2'd2,1'b1,1'b1,1'b0,9'd4},
    {1'b0,4'h0,8'd0, 3'd3,2'd0,1'b0,1'b1,1'b0,9'd8},   // R6 stall
    {1'b1,4'h7,8'd0, 3'd3,2'd2,1'b1,1'b1,1'b0,9'd8},
    {1'b1,4'h3,8'd9, 3'd4,2'd3,1'b1,1'b0,1'b1,9'd12},  // R5 tail takes nothing
    {1'b1,4'h2,8'd4, 3'd1,2'd1,1'b1,1'b1,1'b0,9'd16},  // n=1
    {1'b1,4'h0,8'd0, 3'd2,2'd2,1'b1,1'b1,1'b0,9'd4},
    {1'b0,4'h0,8'd0, 3'd4,2'd3,1'b1,1'b0,1'b1,9'd8},
    {1'b1,4'h0,8'd3, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd12},  // R2 type 0 idle
    {1'b1,4'hF,8'd7, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd0},   // R2 low bits 7 idle
    {1'b1,4'h9,8'd0, 3'd1,2'd1,1'b1,1'b1,1'b0,9'd0},   // R2 bit43 ignored, L=0
    {1'b1,4'h0,8'd0, 3'd2,2'd2,1'b1,1'b1,1'b0,9'd4},
    {1'b0,4'h0,8'd0, 3'd4,2'd3,1'b1,1'b0,1'b1,9'd8},
    {1'b0,4'h0,8'd0, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd12},
    {1'b0,4'h0,8'd0, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd0},
    {1'b1,4'h6,8'd5, 3'd1,2'd1,1'b1,1'b1,1'b0,9'd0},   // R3 L=5 rounds up
    {1'b1,4'h0,8'd0, 3'd2,2'd2,1'b1,1'b1,1'b0,9'd4},
    {1'b1,4'h0,8'd0, 3'd3,2'd2,1'b1,1'b1,1'b0,9'd8},
    {1'b0,4'h0,8'd0, 3'd4,2'd3,1'b1,1'b0,1'b1,9'd12},
    {1'b0,4'h0,8'd0, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd16},
    {1'b0,4'h0,8'd0, 3'd0,2'd0,1'b1,1'b1,1'b0,9'd0}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [11:0] tag);
    @(negedge clk);
    rec_valid = v;
    rec_tag   = tag;
    #(TCK/2 - 2ns);
  endtask

  initial begin
    #(TCK * 5000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n3;
    logic [15:0] eb;
    logic [1:0]  rp [0:2];
    logic [11:0] tp [0:2];

    repeat (3) @(negedge clk);
    #1ns;
    // R1 reset state
    chk("R1 reset", {word_sel, vpar_mode, word_en, rec_ready, last_word, byte_count},
        {3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 9'd0});
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8 walk of the vector table
    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i][29], TBL[i][28:17]);
      chk($sformatf("R3/R4/R5/R6/R7/R8 row %0d", i),
          {word_sel, vpar_mode, word_en, rec_ready, last_word, byte_count},
          TBL[i][16:0]);
    end

    // R9 R10 header and idle word forming
    rp[0] = 2'b10; tp[0] = 12'h1_08;
    rp[1] = 2'b01; tp[1] = 12'hA_5C;
    rp[2] = 2'b11; tp[2] = 12'h6_FF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rec_valid = 1'b0;
      fab_rdy   = rp[k];
      rec_tag   = tp[k];
      #1ns;
      eb = {rp[k], tp[k][11:8], 2'b00, tp[k][7:0]};
      chk($sformatf("R9 base_hdr %0d", k), 64'(base_hdr), 64'(eb));
      chk($sformatf("R10 idle_word %0d", k), 64'(idle_word),
          64'({eb, ~rp[k], 4'b1111, 2'b11, ~tp[k][7:0]}));
    end

    // R3 R7 longest frame, L=255 -> 64 records
    drive(1'b0, 12'h000);
    drive(1'b1, 12'h5_FF);
    chk("R3 long head", 64'(word_sel), 64'd1);
    n3 = 0;
    for (int c = 0; c < 80; c++) begin
      drive(1'b1, 12'h000);
      if (word_sel == 3'd3) n3++;
      if (word_sel == 3'd4) begin
        chk("R7 long tail count", 64'(byte_count), 64'd260);
        chk("R8 long tail last", 64'(last_word), 64'd1);
        break;
      end
    end
    chk("R3 long data words", 64'(n3), 64'd63);
    drive(1'b0, 12'h000);
    chk("R7 count after tail", 64'(byte_count), 64'd264);

    // R11 asynchronous reset mid-frame
    drive(1'b1, 12'h4_20);
    drive(1'b1, 12'h000);
    drive(1'b1, 12'h000);
    chk("R11 mid-frame", 64'(word_sel), 64'd3);
    @(negedge clk);
    rec_valid = 1'b0;
    #3ns;
    rst_n = 1'b0;
    #1ns;
    chk("R11 reset at once", {word_sel, vpar_mode, word_en, rec_ready, last_word, byte_count},
        {3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 9'd0});
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 12'h1_04);
    chk("R11 restart", 64'(word_sel), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule